// File: doc/BRIEF.md
# Prime-Field Modular Adder-Subtractor

This block adds or subtracts two field elements modulo a fixed prime in one clock. A caller sets the two operands and an operation select, then pulses start. On the next clock edge the block registers a result that is already in the range 0 to p-1 and raises done for exactly one cycle. The result register keeps that value until the next start.

Both operations share one datapath. A first adder forms the raw value: the operand sum for addition, or the operand difference for subtraction. A second adder applies a correction constant chosen by the operation select: minus p for addition, plus p for subtraction. Addition keeps the corrected value when the raw sum is not below p. Subtraction keeps it when the difference borrowed. Because both operands are already reduced, one correction is always enough. The prime is a parameter and defaults to 2^255 - 19.

Top module: `field_addsub`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and after it is released, `result` reads 0 and `done` reads 0 until the first start.
- R2: With `opSub` = 0 and `opA + opB` below p, the result registered on the start edge equals `opA + opB`.
- R3: With `opSub` = 0 and `opA + opB` at or above p, the result equals `opA + opB - p`. A sum of exactly p gives 0.
- R4: With `opSub` = 1 and `opA >= opB`, the result equals `opA - opB`.
- R5: With `opSub` = 1 and `opA < opB`, the result equals `opA + p - opB`.
- R6: `done` is 1 in exactly the cycle after each clock edge where `startIn` is sampled high, and 0 otherwise. Starts on consecutive cycles give `done` on consecutive cycles, each with its own result.
- R7: When `startIn` is low, the operands and `opSub` have no effect: `result` holds its last value.
- R8: For operands in 0 to p-1, every registered result lies in 0 to p-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe. Operands are taken on the edge where this is high |
| opSub | input | 1 | 0 selects addition, 1 selects subtraction |
| opA | input | 256 | First operand, within 0 to p-1 |
| opB | input | 256 | Second operand, within 0 to p-1 |
| result | output | 256 | Registered, reduced result |
| done | output | 1 | One-cycle pulse, the cycle after start |

## Verification
A wrong correction decision shows up in the very next cycle as a result that is off by exactly p. A missing wrap leaves a value at or above p. A spurious wrap gives a value far from the operands. The vectors therefore sit on either side of each decision point: a sum of p-1, p, and 2p-2, and a difference of 0, -1, and -(p-1). A stuck or stretched control flop shows as `done` missing, or lasting two cycles, around single and back-to-back starts. A load path that ignores start shows as a result that drifts while the operands change with start low.

// File: rtl/field_addsub_pkg.sv
package field_addsub_pkg;
  typedef struct packed {
    logic load;
    logic isSub;
  } fasStrobe_t;
endpackage

// File: rtl/fas_ctrl.sv
module fas_ctrl
  import field_addsub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       opSub,
  output fasStrobe_t strobe,
  output logic       done
);
  logic doneReg;

  always_comb begin
    strobe.load  = startIn & rstN;
    strobe.isSub = opSub;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneReg <= 1'b0;
    else       doneReg <= startIn;
  end

  assign done = doneReg;

  // R6: a start is followed by done in the next cycle
  a_r6_done_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> done);
  // R6: no start, no done
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !done);
endmodule

// File: rtl/fas_datapath.sv
module fas_datapath
  import field_addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 256,
  parameter logic [WIDTH-1:0] PRIME = 256'h7FFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFED
) (
  input  logic             clk,
  input  logic             rstN,
  input  fasStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result
);
  localparam int unsigned EXT = WIDTH + 1;
  localparam logic [EXT-1:0] PRIME_EXT = {1'b0, PRIME};
  localparam logic [EXT-1:0] NEG_PRIME = ~PRIME_EXT + 1'b1;

  logic [EXT-1:0] bTerm;
  logic [EXT-1:0] rawVal;
  logic [EXT-1:0] corrConst;
  logic [EXT-1:0] corrVal;
  logic           needFix;
  logic [WIDTH-1:0] nextRes;
  logic [WIDTH-1:0] resReg;

  // Stage 1: one adder, with operand B negated for subtraction
  always_comb begin
    bTerm  = strobe.isSub ? (~{1'b0, opB} + 1'b1) : {1'b0, opB};
    rawVal = {1'b0, opA} + bTerm;
  end

  // Stage 2: the correction constant is chosen by the operation
  always_comb begin
    corrConst = strobe.isSub ? PRIME_EXT : NEG_PRIME;
    corrVal   = rawVal + corrConst;
    needFix   = strobe.isSub ? rawVal[WIDTH] : (rawVal >= PRIME_EXT);
    nextRes   = needFix ? corrVal[WIDTH-1:0] : rawVal[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            resReg <= '0;
    else if (strobe.load) resReg <= nextRes;
  end

  assign result = resReg;

  // R8: every loaded result is reduced
  a_r8_in_range: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> (resReg < PRIME));
  // R7: without a load the result register holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) |-> $stable(resReg));
  // R2: an addition without wrap never yields less than operand A
  a_r2_add_plain: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.load) && !$past(strobe.isSub) && !$past(needFix)) |-> (resReg >= $past(opA)));
  // R3: an addition that wraps yields less than operand A
  a_r3_add_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.load) && !$past(strobe.isSub) && $past(needFix)) |-> (resReg < $past(opA)));
  // R4: a subtraction without borrow never exceeds operand A
  a_r4_sub_plain: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.load) && $past(strobe.isSub) && !$past(needFix)) |-> (resReg <= $past(opA)));
  // R5: a subtraction with borrow exceeds operand A
  a_r5_sub_borrow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.load) && $past(strobe.isSub) && $past(needFix)) |-> (resReg > $past(opA)));
endmodule

// File: rtl/field_addsub.sv
module field_addsub
  import field_addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 256,
  parameter logic [WIDTH-1:0] PRIME = 256'h7FFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFED
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             opSub,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  fasStrobe_t strobe;

  fas_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .opSub   (opSub),
    .strobe  (strobe),
    .done    (done)
  );

  fas_datapath #(.WIDTH(WIDTH), .PRIME(PRIME)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: tb/sim_field_addsub.sv
`timescale 1ns/100ps
module sim_field_addsub;
  localparam logic [255:0] P = 256'h7FFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFED;
  localparam int NV = 10;
  localparam logic         V_SUB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [255:0] V_A [NV] = '{256'd1, P-256'd1, P-256'd1, 256'd0, P-256'd5,
                                         256'd5, 256'd3, 256'd0, P-256'd1, 256'd77};
  localparam logic [255:0] V_B [NV] = '{256'd2, 256'd1, P-256'd1, 256'd0, 256'd4,
                                         256'd3, 256'd5, P-256'd1, P-256'd1, 256'd78};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic opSub = 1'b0;
  logic [255:0] opA = '0;
  logic [255:0] opB = '0;
  logic [255:0] result;
  logic done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  field_addsub u0 (.clk(clk), .rstN(rstN), .startIn(startIn), .opSub(opSub),
                   .opA(opA), .opB(opB), .result(result), .done(done));

  function automatic logic [255:0] refOp(input logic sub, input logic [255:0] a, input logic [255:0] b);
    logic [257:0] t;
    if (!sub) t = {2'b0, a} + {2'b0, b};
    else      t = {2'b0, a} + {2'b0, P} - {2'b0, b};
    if (t >= {2'b0, P}) t = t - {2'b0, P};
    return t[255:0];
  endfunction

  task automatic checkVal(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic sub, input logic [255:0] a, input logic [255:0] b);
    @(negedge clk);
    opSub = sub; opA = a; opB = b; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    checkVal({req, " done"}, {255'd0, done}, 256'd1);
    checkVal({req, " result"}, result, refOp(sub, a, b));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] held;
    // R1: reset state
    #12;
    checkVal("R1 reset result", result, '0);
    checkVal("R1 reset done", {255'd0, done}, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 after release done", {255'd0, done}, '0);
    checkVal("R1 after release result", result, '0);

    // Vector table: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      runOp(V_SUB[i] ? "R4/R5 sub" : "R2/R3 add", V_SUB[i], V_A[i], V_B[i]);
      checks++;
      if (result >= P) begin
        errors++;
        $display("FAIL R8 actual=%h expected=below p", result);
      end
    end

    // R3: a sum of exactly p wraps to 0
    runOp("R3 sum equals p", 1'b0, P - 256'd10, 256'd10);
    checkVal("R3 zero", result, '0);
    // R5: 0 - 1 gives p - 1
    runOp("R5 minus one", 1'b1, 256'd0, 256'd1);
    checkVal("R5 p-1", result, P - 256'd1);
    // R2: large sum just under p
    runOp("R2 p-1", 1'b0, P - 256'd2, 256'd1);
    checkVal("R2 p-1 value", result, P - 256'd1);

    // R6: done lasts a single cycle
    @(negedge clk);
    checkVal("R6 done single", {255'd0, done}, '0);

    // R6: back-to-back starts
    @(negedge clk);
    opSub = 1'b0; opA = 256'd100; opB = 256'd200; startIn = 1'b1;
    @(negedge clk);
    checkVal("R6 b2b first done", {255'd0, done}, 256'd1);
    checkVal("R6 b2b first result", result, 256'd300);
    opSub = 1'b1; opA = 256'd7; opB = 256'd9;
    @(negedge clk);
    startIn = 1'b0;
    checkVal("R6 b2b second done", {255'd0, done}, 256'd1);
    checkVal("R6 b2b second result", result, P - 256'd2);
    @(negedge clk);
    checkVal("R6 b2b done drops", {255'd0, done}, '0);

    // R7: operand changes without start are ignored
    held = result;
    for (int k = 0; k < 4; k++) begin
      opSub = k[0]; opA = 256'd1000 + k; opB = 256'd3 * k;
      @(negedge clk);
      checkVal("R7 hold result", result, held);
      checkVal("R7 hold done", {255'd0, done}, '0);
    end

    // R1: reset mid-run clears result
    rstN = 1'b0;
    #1;
    checkVal("R1 mid reset result", result, '0);
    checkVal("R1 mid reset done", {255'd0, done}, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule